// File: doc/BRIEF.md
# DRAM Refresh Interval Scheduler

This block times the periodic refresh of a DRAM and tells the memory controller how many refresh commands it still has to issue. The single refresh interval comes from the memory clock frequency in MHz, so that 8192 refreshes fit into each 64 ms retention window. At 400 MHz that works out to 3125 cycles, or 7.8125 µs. While the block is enabled, a free-running interval counter adds refresh debt each time it expires. The debt is either one refresh per single interval or, in burst mode, eight refreshes per interval eight times as long. Burst mode lets the controller postpone refreshes and issue them back to back.

The controller sees a request line that stays high while any debt remains, and a count of the refreshes owed. Each one-cycle acknowledge retires one refresh. Debt that would go past a fixed ceiling is clipped, and a sticky flag is raised. The interval counter restarts when it expires, whatever the acknowledge timing, so the long-term refresh rate does not drift with controller latency.

Top module: `refresh_sched`

## Requirements
- R1: In single mode (burstSel=0) the interval is SINGLE=(64000*MEM_MHZ)/8192 clocks. With enable high from the first rising edge, owed count becomes 1 at that edge's SINGLE-th rising edge and not before.
- R2: In burst mode (burstSel=1) the interval is BURST_MULT*SINGLE clocks, and each expiry adds BURST_MULT (8 by default) to the owed count.
- R3: An expiry sets the owed count to min(MAX_PEND, owed + step − accepted acknowledge). When the unclipped value exceeds MAX_PEND, overflow goes high and stays high until reset, even across acknowledges and enable changes.
- R4: An acknowledge sampled high while enable is high and the owed count is nonzero lowers the count by exactly one. An acknowledge at owed count zero is ignored and leaves the count at zero.
- R5: refReq is high in exactly those cycles where the owed count is nonzero, and it can only rise after an expiry.
- R6: A clock edge with enable low clears the owed count and restarts the interval counter, so refReq is low one edge later and stays low while enable is low.
- R7: The interval counter restarts on expiry, not on acknowledge. With a continuous enable, expiries fall every SINGLE clocks regardless of when acknowledges arrive.
- R8: An expiry and an accepted acknowledge on the same edge net to owed + step − 1 (single mode: the count is unchanged).
- R9: After reset the owed count is 0, and refReq and overflow are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Refresh generation enable |
| burstSel | input | 1 | 1 = postponed burst mode, 0 = one refresh per interval |
| refAck | input | 1 | One refresh issued (one pulse per refresh) |
| refReq | output | 1 | Refresh debt outstanding |
| pendCount | output | clog2(MAX_PEND+1) | Number of refreshes owed |
| overflow | output | 1 | Sticky: debt was clipped at MAX_PEND |

## Verification
The bench aims at exact expiry edges: the last cycle before the first expiry and the expiry itself. A counter that is off by one would raise the request a cycle early or late, and a burst mode that stretched the interval but still added one refresh would show a count of 1 instead of 8. It puts an acknowledge on the same edge as an expiry. It also lets debt pile up past the ceiling, where a design without clipping would wrap the count, and one that cleared the flag on acknowledge would lose overflow. Long random runs with enable and mode toggles check that the counter restarts on disable and that an acknowledge at zero debt never wraps the count to its maximum.

// File: rtl/refresh_sched_pkg.sv
package refresh_sched_pkg;
  // Strobes from interval control to debt datapath
  typedef struct packed {
    logic expire;   // interval elapsed this cycle
    logic burst;    // step size select for this expiry
    logic consume;  // accepted acknowledge
    logic clear;    // generation disabled
  } refStrobe_t;
endpackage

// File: rtl/refresh_ctrl.sv
module refresh_ctrl
  import refresh_sched_pkg::*;
#(
  parameter int SINGLE_CLKS = 3125,
  parameter int BURST_MULT  = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       burstSel,
  input  logic       refAck,
  input  logic       pendNonZero,
  output refStrobe_t strobe
);
  localparam int BURST_CLKS = SINGLE_CLKS * BURST_MULT;
  localparam int CNT_W      = $clog2(BURST_CLKS + 1);
  localparam logic [CNT_W-1:0] SINGLE_LAST = CNT_W'(SINGLE_CLKS - 1);
  localparam logic [CNT_W-1:0] BURST_LAST  = CNT_W'(BURST_CLKS - 1);

  logic [CNT_W-1:0] intervalCnt;
  logic [CNT_W-1:0] lastCount;
  logic             expireNow;

  assign lastCount = burstSel ? BURST_LAST : SINGLE_LAST;
  // >= so a mode switch to a shorter interval expires at once
  assign expireNow = enable && (intervalCnt >= lastCount);

  always_ff @(posedge clk) begin
    if (!rstN || !enable || expireNow) intervalCnt <= '0;
    else                               intervalCnt <= intervalCnt + 1'b1;
  end

  always_comb begin
    strobe.expire  = expireNow;
    strobe.burst   = burstSel;
    strobe.consume = enable && refAck && pendNonZero;
    strobe.clear   = !enable;
  end
endmodule

// File: rtl/refresh_dp.sv
module refresh_dp
  import refresh_sched_pkg::*;
#(
  parameter int BURST_MULT = 8,
  parameter int MAX_PEND   = 20,
  parameter int PEND_W     = $clog2(MAX_PEND + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  refStrobe_t        strobe,
  output logic [PEND_W-1:0] pendCount,
  output logic              pendNonZero,
  output logic              overflow
);
  localparam int SUM_W = $clog2(MAX_PEND + BURST_MULT + 1);

  logic [PEND_W-1:0] pendQ;
  logic              ovfQ;
  logic [SUM_W-1:0]  stepVal;
  logic [SUM_W-1:0]  sumVal;
  logic              clipNow;
  logic [PEND_W-1:0] pendNext;

  assign stepVal = strobe.burst ? SUM_W'(BURST_MULT) : SUM_W'(1);
  assign sumVal  = SUM_W'(pendQ) + stepVal - SUM_W'(strobe.consume);
  assign clipNow = strobe.expire && (sumVal > SUM_W'(MAX_PEND));

  always_comb begin
    if (strobe.clear)       pendNext = '0;
    else if (clipNow)       pendNext = PEND_W'(MAX_PEND);
    else if (strobe.expire) pendNext = PEND_W'(sumVal);
    else                    pendNext = pendQ - PEND_W'(strobe.consume);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= '0;
      ovfQ  <= 1'b0;
    end else begin
      pendQ <= pendNext;
      if (clipNow) ovfQ <= 1'b1;
    end
  end

  assign pendCount   = pendQ;
  assign pendNonZero = |pendQ;
  assign overflow    = ovfQ;
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refresh_sched_pkg::*;
#(
  parameter int MEM_MHZ    = 400,
  parameter int BURST_MULT = 8,
  parameter int MAX_PEND   = 20,
  parameter int PEND_W     = $clog2(MAX_PEND + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              burstSel,
  input  logic              refAck,
  output logic              refReq,
  output logic [PEND_W-1:0] pendCount,
  output logic              overflow
);
  // 8192 refreshes per 64 ms window
  localparam int SINGLE_CLKS = (64000 * MEM_MHZ) / 8192;

  refStrobe_t strobe;
  logic       pendNonZero;

  refresh_ctrl #(
    .SINGLE_CLKS(SINGLE_CLKS),
    .BURST_MULT (BURST_MULT)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .burstSel   (burstSel),
    .refAck     (refAck),
    .pendNonZero(pendNonZero),
    .strobe     (strobe)
  );

  refresh_dp #(
    .BURST_MULT(BURST_MULT),
    .MAX_PEND  (MAX_PEND),
    .PEND_W    (PEND_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .pendCount  (pendCount),
    .pendNonZero(pendNonZero),
    .overflow   (overflow)
  );

  assign refReq = pendNonZero;
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk
  import refresh_sched_pkg::*;
#(
  parameter int MAX_PEND = 20,
  parameter int PEND_W   = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              refAck,
  input logic              refReq,
  input logic [PEND_W-1:0] pendCount,
  input logic              overflow,
  input refStrobe_t        strobe
);
  p_pend_bounded_r3: assert property (@(posedge clk) disable iff (!rstN)
    pendCount <= PEND_W'(MAX_PEND));

  p_no_overflow_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  p_ack_dec_r4: assert property (@(posedge clk) disable iff (!rstN)
    (enable && refAck && pendCount != '0 && !strobe.expire)
      |=> pendCount == $past(pendCount) - PEND_W'(1));

  p_ack_zero_ignored_r4: assert property (@(posedge clk) disable iff (!rstN)
    (enable && pendCount == '0 && !strobe.expire) |=> pendCount == '0);

  p_req_after_expire_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(refReq) |-> $past(strobe.expire));

  p_disable_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (pendCount == '0 && !refReq));
endmodule

bind refresh_sched refresh_sched_chk #(
  .MAX_PEND(MAX_PEND),
  .PEND_W  (PEND_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .enable   (enable),
  .refAck   (refAck),
  .refReq   (refReq),
  .pendCount(pendCount),
  .overflow (overflow),
  .strobe   (strobe)
);

// File: tb/refresh_sched_tb.sv
module refresh_sched_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MHZ        = 16;    // single interval 125 clocks
  localparam int MULT       = 8;
  localparam int MAXP       = 20;
  localparam int PW         = $clog2(MAXP + 1);
  localparam int SINGLE     = (64000 * MHZ) / 8192;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic burstSel = 1'b0;
  logic refAck = 1'b0;
  logic refReq;
  logic [PW-1:0] pendCount;
  logic overflow;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  refresh_sched #(.MEM_MHZ(MHZ), .BURST_MULT(MULT), .MAX_PEND(MAXP)) u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .burstSel(burstSel),
    .refAck(refAck), .refReq(refReq), .pendCount(pendCount), .overflow(overflow)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference model built from the requirements
  int mCnt = 0;
  int mPend = 0;
  bit mOvf = 1'b0;

  function automatic int intervalOf(bit burst);
    return burst ? SINGLE * MULT : SINGLE;
  endfunction

  function automatic int afterExpiry(int pend, bit burst, bit cons);
    int s = pend + (burst ? MULT : 1) - (cons ? 1 : 0);
    return (s > MAXP) ? MAXP : s;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mPend = 0; mOvf = 1'b0;
    end else if (!enable) begin
      mCnt = 0; mPend = 0;
    end else begin
      bit exp;
      bit cons;
      exp  = (mCnt >= intervalOf(burstSel) - 1);
      cons = refAck && (mPend > 0);
      if (exp) begin
        if (mPend + (burstSel ? MULT : 1) - (cons ? 1 : 0) > MAXP) mOvf = 1'b1;
        mPend = afterExpiry(mPend, burstSel, cons);
        mCnt  = 0;
      end else begin
        mPend = mPend - (cons ? 1 : 0);
        mCnt  = mCnt + 1;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(posedge clk);
    #1;
    check("R9 pend", int'(pendCount), 0);
    check("R9 req", int'(refReq), 0);
    check("R9 ovf", int'(overflow), 0);
    @(negedge clk) rstN = 1'b1;

    // R1 single interval, first expiry on edge SINGLE
    @(negedge clk) enable = 1'b1;
    repeat (SINGLE - 1) @(posedge clk);
    #1 check("R1 before expiry", int'(pendCount), 0);
    @(posedge clk);
    #1 check("R1 at expiry", int'(pendCount), 1);
    check("R5 req high", int'(refReq), 1);

    // R4 ack retires one, then ack at zero ignored
    @(negedge clk) refAck = 1'b1;
    @(negedge clk) refAck = 1'b0;
    check("R4 ack dec", int'(pendCount), 0);
    check("R5 req low", int'(refReq), 0);
    refAck = 1'b1;
    @(negedge clk) refAck = 1'b0;
    check("R4 ack at zero", int'(pendCount), 0);

    // R7 next expiry at edge 2*SINGLE regardless of ack timing
    repeat (SINGLE - 3) @(posedge clk);
    #1 check("R7 before second", int'(pendCount), 0);
    @(posedge clk);
    #1 check("R7 second expiry", int'(pendCount), 1);

    // R8 ack on the expiry edge
    repeat (SINGLE - 1) @(posedge clk);
    @(negedge clk) refAck = 1'b1;
    @(posedge clk);
    #1 check("R8 same edge", int'(pendCount), 1);
    @(negedge clk) refAck = 1'b0;

    // R6 disable clears
    enable = 1'b0;
    @(posedge clk);
    #1 check("R6 cleared", int'(pendCount), 0);
    check("R6 req low", int'(refReq), 0);
    repeat (300) @(posedge clk);
    #1 check("R6 stays off", int'(refReq), 0);

    // R2 burst interval and step
    @(negedge clk) begin enable = 1'b1; burstSel = 1'b1; end
    repeat (SINGLE * MULT - 1) @(posedge clk);
    #1 check("R2 before burst", int'(pendCount), 0);
    @(posedge clk);
    #1 check("R2 burst step", int'(pendCount), MULT);
    repeat (SINGLE * MULT) @(posedge clk);
    #1 check("R2 second burst", int'(pendCount), 2 * MULT);
    check("R3 no ovf yet", int'(overflow), 0);
    repeat (SINGLE * MULT) @(posedge clk);
    #1 check("R3 clipped", int'(pendCount), MAXP);
    check("R3 ovf set", int'(overflow), 1);

    // R3 sticky across acks
    @(negedge clk) refAck = 1'b1;
    repeat (MAXP) @(posedge clk);
    @(negedge clk) refAck = 1'b0;
    check("R4 drained", int'(pendCount), 0);
    check("R3 ovf sticky", int'(overflow), 1);
    enable = 1'b0;
    @(negedge clk);
    check("R3 ovf after disable", int'(overflow), 1);

    // Random phase against the model
    rstN = 1'b0; burstSel = 1'b0;
    @(negedge clk);
    @(negedge clk) begin rstN = 1'b1; enable = 1'b1; end
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      check("R4 random pend", int'(pendCount), mPend);
      check("R5 random req", int'(refReq), (mPend != 0) ? 1 : 0);
      check("R3 random ovf", int'(overflow), int'(mOvf));
      refAck = ($urandom_range(0, 99) < 1);
      if ($urandom_range(0, 2999) == 0) enable = ~enable;
      if ($urandom_range(0, 1999) == 0) burstSel = ~burstSel;
      if (i == 20000) begin enable = 1'b1; refAck = 1'b1; end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule